// File: doc/BRIEF.md
# Manchester Serial Word Transceiver

This block sends and receives single 16-bit words on a half-duplex, multi-drop command/response bus that uses Manchester bi-phase line coding. The line is modelled as a differential pair: driving high puts the positive leg high and the negative leg low, driving low does the opposite, and an undriven line leaves both legs low. The block is clocked at the oversampling rate, `OSR` clocks per bit time (8 or more), so a 1 Mbps line needs an 8 MHz or faster clock.

A transmitted word is 20 bit times long. It starts with a three-bit-time sync whose polarity marks the word type. Sixteen Manchester-coded information bits follow, most significant first, and then an odd parity bit. The receiver locks onto the one transition in the middle of the sync, which is the only place on a valid line where one level lasts longer than one bit time. It times every later half-bit sample from that edge. It reports each word with a single-cycle valid or error pulse. The receiver stays deaf while the transmitter is active, because the bus is half duplex.

Top module: `mbus_word_xcvr`

## Requirements
- R1: A command/status word begins with a sync of three half-bits of the high level followed by three of the low level; a data word uses the inverse (low three, then high three). Every half-bit lasts OSR/2 clocks.
- R2: After the sync the 16 information bits are sent most significant bit first; a 1 is sent as high then low and a 0 as low then high.
- R3: A parity bit, coded like the data bits, follows bit 0 and makes the count of ones over the 16 bits and the parity odd. The word then ends: the busy flag is high for exactly 40 half-bits, and both line legs are low outside a word.
- R4: A start request while a word is being sent is ignored and does not change the waveform or the length of the word in progress.
- R5: A correctly coded received word raises `rx_valid` for one clock, presents the 16 bits on `rx_word`, and sets `rx_cmd` to 1 for a high-then-low sync and to 0 for a low-then-high sync.
- R6: A received word whose parity is not odd raises `rx_err` for one clock and gives no valid pulse. `rx_valid` and `rx_err` are never high together.
- R7: A received bit cell whose two halves carry the same level (no transition in the middle) makes the word end with `rx_err` and no valid pulse.
- R8: While the transmitter is busy the receiver ignores the line. A word that arrives during that time gives neither a valid nor an error pulse.
- R9: Words that follow one another with no gap, so that the end of one word runs into the sync of the next, are each received with their own valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, OSR times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Request to send the word on `tx_word` |
| tx_word | input | 16 | Word to send |
| tx_cmd | input | 1 | 1: command/status sync, 0: data sync |
| tx_p | output | 1 | Positive transmit leg |
| tx_n | output | 1 | Negative transmit leg |
| tx_busy | output | 1 | High while a word is on the line |
| rx_p | input | 1 | Positive receive leg |
| rx_n | input | 1 | Negative receive leg |
| rx_valid | output | 1 | One-clock pulse: a good word was received |
| rx_err | output | 1 | One-clock pulse: a word with bad parity or coding was received |
| rx_word | output | 16 | Last good received word |
| rx_cmd | output | 1 | Type of the last good received word |

## Verification
A wrong half-bit counter or pattern register in the transmitter shows on the legs within one half-bit: a sample taken at the centre of every half-bit is compared with the expected level, and the busy length is compared too. In the receiver, a wrong sync timing or a wrong sample point shifts the recovered bits or the parity result. This shows at the end of the same word as a wrong `rx_word`, a wrong type, or an error pulse in place of a valid pulse. Faults in the half-duplex gating and in the handling of back-to-back words show as an extra or missing pulse within one word time.

// File: rtl/mbus_word_xcvr.sv
module mbus_word_xcvr #(
  parameter int OSR = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_start,
  input  logic [15:0] tx_word,
  input  logic        tx_cmd,
  output logic        tx_p,
  output logic        tx_n,
  output logic        tx_busy,
  input  logic        rx_p,
  input  logic        rx_n,
  output logic        rx_valid,
  output logic        rx_err,
  output logic [15:0] rx_word,
  output logic        rx_cmd
);
  localparam int H      = OSR / 2;
  localparam int HW     = $clog2(H);
  localparam int NHALF  = 40;
  localparam int RUNMAX = 5 * H;
  localparam int RW     = $clog2(RUNMAX + 1);
  localparam int FLEN   = NHALF * H;
  localparam int LW     = $clog2(FLEN + 1);

  function automatic logic [NHALF-1:0] frame_of(input logic [15:0] w, input logic c);
    logic [NHALF-1:0] r;
    r[39:34] = c ? 6'b111000 : 6'b000111;
    for (int i = 0; i < 16; i++)
      r[33-2*i -: 2] = w[15-i] ? 2'b10 : 2'b01;
    r[1:0] = (~^w) ? 2'b10 : 2'b01;
    return r;
  endfunction

  // transmitter
  logic [NHALF-1:0] pat;
  logic [HW-1:0]    tcnt;
  logic [5:0]       tidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      pat     <= '0;
      tcnt    <= '0;
      tidx    <= '0;
    end else if (!tx_busy && tx_start) begin
      tx_busy <= 1'b1;
      pat     <= frame_of(tx_word, tx_cmd);
      tcnt    <= '0;
      tidx    <= '0;
    end else if (tx_busy) begin
      if (tcnt == HW'(H-1)) begin
        tcnt <= '0;
        pat  <= pat << 1;
        if (tidx == 6'(NHALF-1)) tx_busy <= 1'b0;
        else                     tidx    <= tidx + 6'd1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign tx_p = tx_busy &  pat[NHALF-1];
  assign tx_n = tx_busy & ~pat[NHALF-1];

  // receiver: line symbol history and run length
  logic [1:0]    sym, lsym;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym  <= 2'b00;
      lsym <= 2'b00;
      run  <= '0;
    end else begin
      sym  <= {rx_p, rx_n};
      lsym <= sym;
      if (sym != lsym)                 run <= RW'(1);
      else if (run != RW'(RUNMAX))     run <= run + 1'b1;
    end
  end

  wire lvl_ok  = (sym == 2'b10) || (sym == 2'b01);
  wire lvl     = (sym == 2'b10);
  wire sync_ed = ((lsym == 2'b10) && (sym == 2'b01)) || ((lsym == 2'b01) && (sym == 2'b10));
  wire run_ok  = (run >= RW'(3*H-1)) && (run <= RW'(4*H+1));

  logic          rbusy, rtype, first, merr;
  logic [HW-1:0] rcnt;
  logic [5:0]    ridx;
  logic [15:0]   sh;

  wire        bad_half = !lvl_ok || (lvl == first);
  wire [16:0] full     = {sh, first};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbusy    <= 1'b0;
      rtype    <= 1'b0;
      first    <= 1'b0;
      merr     <= 1'b0;
      rcnt     <= '0;
      ridx     <= '0;
      sh       <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      rx_word  <= '0;
      rx_cmd   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (tx_busy) begin
        rbusy <= 1'b0;
      end else if (!rbusy) begin
        rbusy <= sync_ed && run_ok;
        rtype <= (sym == 2'b01);
        rcnt  <= HW'(1);
        ridx  <= '0;
        merr  <= 1'b0;
      end else begin
        if (rcnt == HW'(H-1)) begin
          rcnt <= '0;
          ridx <= ridx + 6'd1;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
        if (rcnt == HW'(H/2)) begin
          if (ridx < 6'd3) begin
            if (!lvl_ok || (lvl == rtype)) rbusy <= 1'b0;
          end else if (ridx[0]) begin
            first <= lvl;
            if (!lvl_ok) merr <= 1'b1;
          end else begin
            sh <= full[15:0];
            if (bad_half) merr <= 1'b1;
            if (ridx == 6'd36) begin
              rbusy <= 1'b0;
              if (merr || bad_half || !(^{sh, first})) begin
                rx_err <= 1'b1;
              end else begin
                rx_valid <= 1'b1;
                rx_word  <= sh;
                rx_cmd   <= rtype;
              end
            end
          end
        end
      end
    end
  end

  // checks
  logic [LW-1:0] blen;
  always_ff @(posedge clk) begin
    if (!rst_n || !tx_busy) blen <= '0;
    else                    blen <= blen + 1'b1;
  end

  initial assert (OSR >= 8 && OSR % 2 == 0);

  AST_TX_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(blen) == LW'(FLEN-1)); // R3
  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err)); // R6
  AST_RX_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !rx_valid && !rx_err); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
endmodule

// File: tb/tb_mbus_word_xcvr.sv
module tb_mbus_word_xcvr;
  localparam int OSR = 8;
  localparam int H   = OSR / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_start = 1'b0;
  logic [15:0] tx_word = '0;
  logic tx_cmd = 1'b0;
  logic tx_p, tx_n, tx_busy;
  logic rx_p = 1'b0, rx_n = 1'b0;
  logic rx_valid, rx_err, rx_cmd;
  logic [15:0] rx_word;

  int checks = 0, failures = 0;
  int vcnt = 0, ecnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbus_word_xcvr #(.OSR(OSR)) dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_word(tx_word), .tx_cmd(tx_cmd),
    .tx_p(tx_p), .tx_n(tx_n), .tx_busy(tx_busy), .rx_p(rx_p), .rx_n(rx_n),
    .rx_valid(rx_valid), .rx_err(rx_err), .rx_word(rx_word), .rx_cmd(rx_cmd));

  always @(posedge clk) begin
    if (rx_valid) vcnt <= vcnt + 1;
    if (rx_err)   ecnt <= ecnt + 1;
  end

  // fields: [18] command sync, [17:16] fault (0 none, 1 parity, 2 no mid-bit transition), [15:0] word
  localparam logic [18:0] VEC [6] = '{
    {1'b1, 2'd0, 16'hA5C3}, {1'b0, 2'd0, 16'h0000}, {1'b1, 2'd0, 16'hFFFF},
    {1'b0, 2'd1, 16'h8001}, {1'b1, 2'd2, 16'h1234}, {1'b0, 2'd0, 16'h7FFE}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] expect_frame(input logic [15:0] w, input logic c, input int fault);
    logic [39:0] f;
    logic par;
    par = ~^w;
    if (fault == 1) par = ~par;
    f[39:34] = c ? 6'b111000 : 6'b000111;
    for (int i = 0; i < 16; i++) f[33-2*i -: 2] = w[15-i] ? 2'b10 : 2'b01;
    f[1:0] = par ? 2'b10 : 2'b01;
    if (fault == 2) f[22] = f[23];
    return f;
  endfunction

  task automatic drive_rx(input logic [39:0] f);
    for (int hi = 0; hi < 40; hi++) begin
      rx_p = f[39-hi];
      rx_n = ~f[39-hi];
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic rx_idle();
    rx_p = 1'b0;
    rx_n = 1'b0;
  endtask

  task automatic run_rx(input logic [18:0] v);
    int v0, e0, fault;
    bit good;
    fault = int'(v[17:16]);
    good = (fault == 0);
    v0 = vcnt; e0 = ecnt;
    drive_rx(expect_frame(v[15:0], v[18], fault));
    rx_idle();
    repeat (2*H) @(negedge clk);
    if (good) begin
      check(vcnt == v0 + 1 && ecnt == e0, "R5 valid pulse", vcnt - v0, 1);
      check(rx_word == v[15:0], "R5 word", rx_word, v[15:0]);
      check(rx_cmd == v[18], "R5 type", rx_cmd, v[18]);
    end else if (fault == 1) begin
      check(ecnt == e0 + 1 && vcnt == v0, "R6 parity error", ecnt - e0, 1);
    end else begin
      check(ecnt == e0 + 1 && vcnt == v0, "R7 coding error", ecnt - e0, 1);
    end
  endtask

  task automatic run_tx(input logic [18:0] v);
    logic [39:0] f;
    int bad;
    f = expect_frame(v[15:0], v[18], 0);
    bad = 0;
    tx_word = v[15:0];
    tx_cmd = v[18];
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int j = 0; j < 40*H; j++) begin
      if (j == 50) begin tx_start = 1'b1; tx_word = ~v[15:0]; tx_cmd = ~v[18]; end
      if (j == 51) tx_start = 1'b0;
      if (j % H == H/2) begin
        if (tx_p !== f[39 - j/H] || tx_n !== ~f[39 - j/H] || tx_busy !== 1'b1) bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, "R1 R2 R4 tx waveform", bad, 0);
    check(tx_busy == 1'b0 && tx_p == 1'b0 && tx_n == 1'b0, "R3 tx end", {tx_busy, tx_p, tx_n}, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(tx_busy == 0 && tx_p == 0 && tx_n == 0 && rx_valid == 0 && rx_err == 0,
          "R3 reset idle", {tx_busy, tx_p, tx_n, rx_valid, rx_err}, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    foreach (VEC[k]) begin
      run_rx(VEC[k]);
      run_tx(VEC[k]);
      repeat (4) @(negedge clk);
    end

    // R9: back-to-back words with no gap
    begin
      int v0;
      v0 = vcnt;
      drive_rx(expect_frame(16'hC0DE, 1'b0, 0));
      drive_rx(expect_frame(16'h0F0F, 1'b1, 0));
      rx_idle();
      repeat (2*H) @(negedge clk);
      check(vcnt == v0 + 2, "R9 two words", vcnt - v0, 2);
      check(rx_word == 16'h0F0F && rx_cmd == 1'b1, "R9 second word", rx_word, 16'h0F0F);
    end

    // R8: a word arriving while transmitting is ignored
    begin
      int v0, e0;
      v0 = vcnt; e0 = ecnt;
      tx_word = 16'h5555; tx_cmd = 1'b1; tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      drive_rx(expect_frame(16'h3C3C, 1'b1, 0));
      rx_idle();
      repeat (2*H) @(negedge clk);
      check(vcnt == v0 && ecnt == e0, "R8 deaf while busy", vcnt - v0 + ecnt - e0, 0);
      check(rx_word == 16'h0F0F, "R8 word unchanged", rx_word, 16'h0F0F);
    end

    // receiver works again after the transmitter finishes
    repeat (2*H) @(negedge clk);
    run_rx({1'b0, 2'd0, 16'h9A5B});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule